// File: doc/BRIEF.md
# Programmable Bus Region Timing Sequencer

This block runs single read and write accesses on one region of an external parallel bus, here a compact-flash card used in PIO mode. An internal master hands it a request over a valid/ready port. The block then drives the address, the write data, an active-low chip enable and separate active-low read and write strobes, and captures the read data into a response register.

Every access runs the same ordered phases: address setup with chip enable still high, a chip-enable-to-strobe delay, the active strobe, a hold with chip enable still low, and an idle pause. Each phase length is a separate configuration field. All of them are counted in units of the I/O clock, and a 2-bit code sets how many clocks make one unit.

When wait mode is on, the device can stretch the strobe by holding its ready line low. The ready line is synchronized before use. A programmable timeout bounds the stretch and raises an error flag. A region-enable bit gates all bus activity.

Top module: `bus_region_timer`

## Requirements
- R1: The multiplier code `cfg_mult` sets the clocks per unit: 0 gives 4, 1 gives 1, 2 gives 2 and 3 gives 8. A phase field of value N lasts (N+1) units, so a field of zero still lasts one unit.
- R2: After a request is accepted, `bus_addr` holds the request address and `bus_ce_n` stays high for (cfg_adr+1) units. `req_ready` is low during this phase.
- R3: `bus_ce_n` then goes low and stays low for (cfg_ces+1) units before any strobe asserts. A strobe is never low while `bus_ce_n` is high.
- R4: A read drives `bus_oe_n` low for (cfg_oe+1) units. A write drives `bus_we_n` low for (cfg_we+1) units and drives `bus_dout` with `bus_dout_en` high. Only one strobe is ever low at a time, and a read never raises `bus_dout_en`.
- R5: After the strobe ends, `bus_ce_n` stays low for (cfg_rdhld+1) units on a read or (cfg_wrhld+1) units on a write.
- R6: An idle pause of (cfg_pause+1) units with all strobes high follows. `req_ready` stays low from acceptance until the pause ends and is high only when the bus is idle.
- R7: A read samples `bus_din` on the clock edge where `bus_oe_n` rises. It returns that value on `rsp_rdata` with `rsp_valid` high for exactly one cycle. A write gives no response.
- R8: While `cfg_en` is 0, an offered request is consumed with `req_ready` staying high. No strobe or chip enable is driven and no response is given.
- R9: With `cfg_waitm` set, the strobe is held while the synchronized `bus_iordy` is low. After it reads high, the strobe continues for (cfg_wait+1) more units. If `bus_iordy` is raised D cycles after the first strobe cycle, the strobe lasts max(base, D+3) cycles plus that wait.
- R10: With `cfg_waitm` clear, `bus_iordy` has no effect on strobe length.
- R11: In wait mode, if `bus_iordy` stays low, the strobe ends after base + `cfg_tmo` cycles and the access finishes normally. `err_flag` then reads 1 until the next accepted request clears it.
- R12: In reset, all three strobes are high, `req_ready` is high, and `rsp_valid` and `err_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Region enable |
| cfg_mult | input | 2 | Unit multiplier code |
| cfg_adr | input | CW | Address setup units minus one |
| cfg_ces | input | CW | Chip-enable-to-strobe units minus one |
| cfg_oe | input | CW | Read strobe units minus one |
| cfg_we | input | CW | Write strobe units minus one |
| cfg_rdhld | input | CW | Read hold units minus one |
| cfg_wrhld | input | CW | Write hold units minus one |
| cfg_pause | input | CW | Trailing pause units minus one |
| cfg_wait | input | CW | Post-ready strobe units minus one |
| cfg_waitm | input | 1 | Wait mode enable |
| cfg_tmo | input | TOW | Ready timeout in clocks |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DW | Captured read data |
| err_flag | output | 1 | Ready timeout occurred on the last access |
| bus_addr | output | AW | Bus address |
| bus_dout | output | DW | Bus write data |
| bus_dout_en | output | 1 | Bus data driver enable |
| bus_din | input | DW | Bus read data |
| bus_iordy | input | 1 | Device ready, asynchronous |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |

## Verification
A wrong phase counter or multiplier decode shows up within one access as a strobe, setup, hold or pause that is too long or too short. The sweep over all four multiplier codes and two field sets measures each phase at the pins. A wrong state transition shows up in the same access: a missing or repeated strobe, the wrong strobe, a read response pulse that is absent or doubled, or `req_ready` returning early. Faults in the ready path appear as strobe lengths that differ from max(base, D+3) plus the wait time, or as a timeout flag that is set without cause or never cleared.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADR,
        ST_CES,
        ST_STRB,
        ST_WEXT,
        ST_HOLD,
        ST_PAUSE
    } brt_state_e;

    // Index of each phase length in the length table
    localparam int PH_ADR = 0;
    localparam int PH_CES = 1;
    localparam int PH_OE  = 2;
    localparam int PH_WE  = 3;
    localparam int PH_RHD = 4;
    localparam int PH_WHD = 5;
    localparam int PH_PAU = 6;
    localparam int PH_WEX = 7;
    localparam int NPH    = 8;

endpackage

// File: rtl/brt_sync2.sv
module brt_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
        end
    end

    assign sync_out = sync_q;
endmodule

// File: rtl/brt_len.sv
// Converts a phase field into a down-counter load value: ((N+1) * mult) - 1
module brt_len #(
    parameter int CW = 4,
    parameter int LW = CW + 4
) (
    input  logic [1:0]    mult_code,
    input  logic [CW-1:0] field,
    output logic [LW-1:0] load
);
    logic [1:0]    shift;
    logic [LW-1:0] units;

    always_comb begin
        unique case (mult_code)
            2'd0:    shift = 2'd2;
            2'd1:    shift = 2'd0;
            2'd2:    shift = 2'd1;
            default: shift = 2'd3;
        endcase
        units = LW'(field) + LW'(1);
        load  = (units << shift) - LW'(1);
    end
endmodule

// File: rtl/brt_seq.sv
module brt_seq
    import brt_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int LW  = 8,
    parameter int TOW = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_en,
    input  logic                   cfg_waitm,
    input  logic [TOW-1:0]         cfg_tmo,
    input  logic [NPH-1:0][LW-1:0] len_tab,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [AW-1:0]          req_addr,
    input  logic [DW-1:0]          req_wdata,
    output logic                   rsp_valid,
    output logic [DW-1:0]          rsp_rdata,
    output logic                   err_flag,
    input  logic                   iordy_s,
    input  logic [DW-1:0]          bus_din,
    output logic [AW-1:0]          bus_addr,
    output logic [DW-1:0]          bus_dout,
    output logic                   bus_dout_en,
    output logic                   bus_ce_n,
    output logic                   bus_oe_n,
    output logic                   bus_we_n
);
    typedef struct packed {
        brt_state_e    state;
        logic [LW-1:0]  cnt;
        logic [TOW-1:0] ext;
        logic           wr;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [DW-1:0]  rdata;
        logic           rsp_v;
        logic           err;
    } seq_t;

    seq_t q, d;
    logic fin;
    logic cnt_zero;

    assign cnt_zero = (q.cnt == '0);

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        fin     = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid && cfg_en) begin
                    d.state = ST_ADR;
                    d.cnt   = len_tab[PH_ADR];
                    d.wr    = req_write;
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.err   = 1'b0;
                end
            end
            ST_ADR: begin
                if (cnt_zero) begin
                    d.state = ST_CES;
                    d.cnt   = len_tab[PH_CES];
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_CES: begin
                if (cnt_zero) begin
                    d.state = ST_STRB;
                    d.cnt   = q.wr ? len_tab[PH_WE] : len_tab[PH_OE];
                    d.ext   = '0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_STRB: begin
                if (!cnt_zero) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (!cfg_waitm) begin
                    fin = 1'b1;
                end else if (iordy_s) begin
                    d.state = ST_WEXT;
                    d.cnt   = len_tab[PH_WEX];
                end else if (q.ext == cfg_tmo) begin
                    fin   = 1'b1;
                    d.err = 1'b1;
                end else begin
                    d.ext = q.ext + 1'b1;
                end
            end
            ST_WEXT: begin
                if (cnt_zero) fin = 1'b1;
                else          d.cnt = q.cnt - 1'b1;
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    d.state = ST_PAUSE;
                    d.cnt   = len_tab[PH_PAU];
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_PAUSE: begin
                if (cnt_zero) d.state = ST_IDLE;
                else          d.cnt   = q.cnt - 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase

        // Strobe release: enter hold, capture read data on the rising OE edge
        if (fin) begin
            d.state = ST_HOLD;
            d.cnt   = q.wr ? len_tab[PH_WHD] : len_tab[PH_RHD];
            if (!q.wr) begin
                d.rdata = bus_din;
                d.rsp_v = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    logic strobing;
    logic ce_on;

    assign strobing    = (q.state == ST_STRB) || (q.state == ST_WEXT);
    assign ce_on       = (q.state == ST_CES) || strobing || (q.state == ST_HOLD);
    assign req_ready   = (q.state == ST_IDLE);
    assign rsp_valid   = q.rsp_v;
    assign rsp_rdata   = q.rdata;
    assign err_flag    = q.err;
    assign bus_addr    = q.addr;
    assign bus_dout    = q.wdata;
    assign bus_dout_en = q.wr && ce_on;
    assign bus_ce_n    = !ce_on;
    assign bus_oe_n    = !(strobing && !q.wr);
    assign bus_we_n    = !(strobing && q.wr);
endmodule

// File: rtl/bus_region_timer.sv
module bus_region_timer
    import brt_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 16,
    parameter int CW  = 4,
    parameter int TOW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_en,
    input  logic [1:0]     cfg_mult,
    input  logic [CW-1:0]  cfg_adr,
    input  logic [CW-1:0]  cfg_ces,
    input  logic [CW-1:0]  cfg_oe,
    input  logic [CW-1:0]  cfg_we,
    input  logic [CW-1:0]  cfg_rdhld,
    input  logic [CW-1:0]  cfg_wrhld,
    input  logic [CW-1:0]  cfg_pause,
    input  logic [CW-1:0]  cfg_wait,
    input  logic           cfg_waitm,
    input  logic [TOW-1:0] cfg_tmo,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic           req_write,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_rdata,
    output logic           err_flag,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_dout,
    output logic           bus_dout_en,
    input  logic [DW-1:0]  bus_din,
    input  logic           bus_iordy,
    output logic           bus_ce_n,
    output logic           bus_oe_n,
    output logic           bus_we_n
);
    localparam int LW = CW + 4;

    logic [NPH-1:0][CW-1:0] fld;
    logic [NPH-1:0][LW-1:0] len_tab;
    logic                   iordy_s;

    assign fld[PH_ADR] = cfg_adr;
    assign fld[PH_CES] = cfg_ces;
    assign fld[PH_OE]  = cfg_oe;
    assign fld[PH_WE]  = cfg_we;
    assign fld[PH_RHD] = cfg_rdhld;
    assign fld[PH_WHD] = cfg_wrhld;
    assign fld[PH_PAU] = cfg_pause;
    assign fld[PH_WEX] = cfg_wait;

    for (genvar g = 0; g < NPH; g++) begin : g_len
        brt_len #(.CW(CW), .LW(LW)) u_len (
            .mult_code (cfg_mult),
            .field     (fld[g]),
            .load      (len_tab[g])
        );
    end

    brt_sync2 u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_iordy),
        .sync_out (iordy_s)
    );

    brt_seq #(.AW(AW), .DW(DW), .LW(LW), .TOW(TOW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_en      (cfg_en),
        .cfg_waitm   (cfg_waitm),
        .cfg_tmo     (cfg_tmo),
        .len_tab     (len_tab),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .err_flag    (err_flag),
        .iordy_s     (iordy_s),
        .bus_din     (bus_din),
        .bus_addr    (bus_addr),
        .bus_dout    (bus_dout),
        .bus_dout_en (bus_dout_en),
        .bus_ce_n    (bus_ce_n),
        .bus_oe_n    (bus_oe_n),
        .bus_we_n    (bus_we_n)
    );
endmodule

// File: rtl/brt_checker.sv
module brt_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic req_valid,
    input logic req_ready,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic rsp_valid
);
    assert_strobe_under_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> !ce_n);

    assert_ce_before_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(oe_n) || $fell(we_n)) |-> $past(!ce_n));

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    assert_idle_when_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ce_n && oe_n && we_n));

    assert_capture_on_oe_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> rsp_valid);

    assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_disabled_stays_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_en) |=> req_ready);
endmodule

bind bus_region_timer brt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ce_n      (bus_ce_n),
    .oe_n      (bus_oe_n),
    .we_n      (bus_we_n),
    .rsp_valid (rsp_valid)
);

// File: tb/bus_region_timer_tb.sv
`timescale 1ns/1ps
module bus_region_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b1;
    logic [1:0]  cfg_mult = 2'd1;
    logic [3:0]  cfg_adr = '0, cfg_ces = '0, cfg_oe = '0, cfg_we = '0;
    logic [3:0]  cfg_rdhld = '0, cfg_wrhld = '0, cfg_pause = '0, cfg_wait = '0;
    logic        cfg_waitm = 1'b0;
    logic [7:0]  cfg_tmo = 8'd20;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid, err_flag, bus_dout_en;
    logic [15:0] rsp_rdata, bus_dout;
    logic [15:0] bus_din = '0;
    logic [7:0]  bus_addr;
    logic        bus_iordy = 1'b1;
    logic        bus_ce_n, bus_oe_n, bus_we_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    bus_region_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mult(cfg_mult),
        .cfg_adr(cfg_adr), .cfg_ces(cfg_ces), .cfg_oe(cfg_oe), .cfg_we(cfg_we),
        .cfg_rdhld(cfg_rdhld), .cfg_wrhld(cfg_wrhld), .cfg_pause(cfg_pause),
        .cfg_wait(cfg_wait), .cfg_waitm(cfg_waitm), .cfg_tmo(cfg_tmo),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .err_flag(err_flag), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
        .bus_iordy(bus_iordy), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
        .bus_we_n(bus_we_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int mfac(input int code);
        case (code)
            0: return 4;
            1: return 1;
            2: return 2;
            default: return 8;
        endcase
    endfunction

    int n0, n1, n2, n3, n4, nrsp, bad;
    logic [15:0] rd;

    // One access, with each phase measured at the pins (sampled on negedges)
    task automatic access(input bit wr, input logic [7:0] a, input logic [15:0] wd);
        bit seen;
        seen = 0;
        n0 = 0; n1 = 0; n2 = 0; n3 = 0; n4 = 0; nrsp = 0; bad = 0; rd = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        bus_din = 16'hA500 ^ {8'h00, a};
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            if (rsp_valid) begin
                nrsp++;
                rd = rsp_rdata;
            end
            if (!bus_oe_n || !bus_we_n) begin
                n2++;
                seen = 1;
                if (wr ? !bus_oe_n : !bus_we_n) bad++;
                if (bus_addr != a) bad++;
                if (wr && (!bus_dout_en || bus_dout != wd)) bad++;
                if (!wr && bus_dout_en) bad++;
            end else if (!bus_ce_n) begin
                if (seen) n3++; else n1++;
            end else if (!req_ready) begin
                if (seen) n4++; else n0++;
            end else begin
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 ce_n in reset", int'(bus_ce_n), 1);
        chk("R12 strobes in reset", int'(bus_oe_n & bus_we_n), 1);
        chk("R12 ready in reset", int'(req_ready), 1);
        chk("R12 rsp/err in reset", int'(rsp_valid | err_flag), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1..R7: sweep over multiplier codes, two field sets, read and write
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                for (int w = 0; w < 2; w++) begin
                    int f;
                    logic [7:0] a;
                    cfg_mult = 2'(m);
                    cfg_adr = (s == 1) ? 4'd2 : 4'd0;
                    cfg_ces = (s == 1) ? 4'd1 : 4'd0;
                    cfg_oe = (s == 1) ? 4'd3 : 4'd0;
                    cfg_we = (s == 1) ? 4'd4 : 4'd0;
                    cfg_rdhld = (s == 1) ? 4'd1 : 4'd0;
                    cfg_wrhld = (s == 1) ? 4'd2 : 4'd0;
                    cfg_pause = (s == 1) ? 4'd3 : 4'd0;
                    f = mfac(m);
                    a = 8'(m * 16 + s * 4 + w + 1);
                    access(w[0], a, 16'h3C00 + 16'(a));
                    chk($sformatf("R1 R2 setup m%0d s%0d w%0d", m, s, w), n0, (int'(cfg_adr) + 1) * f);
                    chk($sformatf("R1 R3 ce-to-strobe m%0d s%0d w%0d", m, s, w), n1, (int'(cfg_ces) + 1) * f);
                    chk($sformatf("R1 R4 strobe m%0d s%0d w%0d", m, s, w), n2,
                        (int'(w ? cfg_we : cfg_oe) + 1) * f);
                    chk($sformatf("R4 strobe pins m%0d s%0d w%0d", m, s, w), bad, 0);
                    chk($sformatf("R1 R5 hold m%0d s%0d w%0d", m, s, w), n3,
                        (int'(w ? cfg_wrhld : cfg_rdhld) + 1) * f);
                    chk($sformatf("R1 R6 pause m%0d s%0d w%0d", m, s, w), n4, (int'(cfg_pause) + 1) * f);
                    chk($sformatf("R7 response count m%0d s%0d w%0d", m, s, w), nrsp, w ? 0 : 1);
                    if (w == 0)
                        chk($sformatf("R7 read data m%0d s%0d", m, s), int'(rd), int'(16'hA500 ^ {8'h00, a}));
                end
            end
        end

        // R8: region disabled
        cfg_mult = 2'd1; cfg_adr = 0; cfg_ces = 0; cfg_oe = 1; cfg_we = 1;
        cfg_rdhld = 0; cfg_wrhld = 0; cfg_pause = 0; cfg_wait = 1;
        cfg_en = 1'b0;
        begin
            int act;
            act = 0;
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h55;
            @(negedge clk);
            req_valid = 1'b0;
            for (int k = 0; k < 20; k++) begin
                if (!bus_ce_n || !bus_oe_n || !bus_we_n || rsp_valid || !req_ready) act++;
                @(negedge clk);
            end
            chk("R8 disabled region no activity", act, 0);
        end
        cfg_en = 1'b1;

        // R10: wait mode off, IORDY low ignored (base strobe 2)
        bus_iordy = 1'b0;
        cfg_waitm = 1'b0;
        access(1'b0, 8'h11, 16'h0);
        chk("R10 strobe with iordy ignored", n2, 2);
        chk("R10 no error", int'(err_flag), 0);

        // R9: wait mode, IORDY already ready: base 2 + wait 2
        bus_iordy = 1'b1;
        cfg_waitm = 1'b1;
        access(1'b0, 8'h12, 16'h0);
        chk("R9 strobe with ready iordy", n2, 4);

        // R9: IORDY released D=6 cycles into strobe: max(2,9)+2 = 11
        bus_iordy = 1'b0;
        cfg_tmo = 8'd20;
        fork
            access(1'b1, 8'h13, 16'hBEEF);
            begin
                @(negedge clk);
                while (bus_we_n) @(negedge clk);
                repeat (6) @(negedge clk);
                bus_iordy = 1'b1;
            end
        join
        chk("R9 strobe stretched by iordy", n2, 11);
        chk("R9 write data held during stretch", bad, 0);
        chk("R9 no timeout error", int'(err_flag), 0);

        // R11: IORDY stuck low, timeout 5: strobe 2+5 = 7, error set
        bus_iordy = 1'b0;
        cfg_tmo = 8'd5;
        access(1'b0, 8'h14, 16'h0);
        chk("R11 strobe ended by timeout", n2, 7);
        chk("R11 error flag set", int'(err_flag), 1);
        chk("R11 access still completes with response", nrsp, 1);
        chk("R11 hold after timeout", n3, 1);

        // R11: next accepted access clears the flag
        bus_iordy = 1'b1;
        access(1'b0, 8'h15, 16'h0);
        chk("R11 error flag cleared", int'(err_flag), 0);
        chk("R9 strobe after clear", n2, 4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule